// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Sequencer

This block drives a single DRAM bank. It records which row, if any, the bank's row buffer holds open. Each read or write request becomes the shortest legal command sequence for that state:

- a column access alone when the request targets the open row;
- an activate followed by the column access when no row is open;
- a precharge, then an activate, then the column access when a different row is open.

Every request is classified as a hit, a miss or a conflict in the cycle it is accepted.

Refresh shares the same command port. A refresh becomes pending when a pulse arrives on the refresh input or when the built-in interval counter expires. While a refresh is pending, new requests are held off. Any open row is closed before the refresh is issued. Programmable wait counts separate each command from the next. A configuration input selects the page policy. Open-page leaves the row open for later hits. Closed-page precharges right after every column access.

Top module: `bank_seq`

## Requirements
- R1: After reset, req_ready is 1, busy is 0, cmd_valid is 0 and ref_pend is 0.
- R2: A request to the open row is classified cls=1 (hit) when accepted and issues only a column command: cmd_op 2 for read (req_we=0) or 3 for write (req_we=1), carrying the request's column.
- R3: A request when no row is open is classified cls=2 (miss) and issues ACTIVATE (cmd_op 1) with the request's row, then the column command.
- R4: A request to a different row while one is open is classified cls=3 (conflict) and issues PRECHARGE (cmd_op 4), then ACTIVATE, then the column command.
- R5: req_ready is 0 whenever busy is 1, so only one sequence runs at a time.
- R6: If a command is issued at cycle c, the next command follows at the earliest at c+cfg_trp+1 after PRECHARGE and at c+cfg_trcd+1 after ACTIVATE. A request waiting at the port is accepted at c+cfg_trfc+1 after REFRESH and at c+cfg_tcl+1 after a column command. A count of zero allows back-to-back commands.
- R7: When a refresh is serviced, any open row is first precharged, then REFRESH (cmd_op 5) is issued. The row buffer is empty afterwards, so the next request is a miss.
- R8: A pulse on ref_req, or the expiry of a nonzero cfg_ref_int cycle interval, sets ref_pend. While ref_pend is 1, req_ready is 0. A refresh is issued only while ref_pend is 1, and it clears ref_pend.
- R9: With cfg_closed=1, every column command is followed by PRECHARGE at c+cfg_tcl+1, and no row is left open.
- R10: With cfg_closed=0, the row stays open after an access, so a later request to it is a hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_closed | input | 1 | 1 selects closed-page policy |
| cfg_trcd | input | DLY_W | Wait cycles after ACTIVATE |
| cfg_trp | input | DLY_W | Wait cycles after PRECHARGE |
| cfg_tcl | input | DLY_W | Wait cycles after a column command |
| cfg_trfc | input | DLY_W | Wait cycles after REFRESH |
| cfg_ref_int | input | RINT_W | Refresh interval in cycles, 0 disables the counter |
| ref_req | input | 1 | Refresh request pulse |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when both valid and ready are high |
| req_row | input | ROW_W | Request row |
| req_col | input | COL_W | Request column |
| req_we | input | 1 | 1 write, 0 read |
| busy | output | 1 | A command sequence is in progress |
| cls_valid | output | 1 | Classification valid (request accepted this cycle) |
| cls | output | 2 | 1 hit, 2 miss, 3 conflict |
| ref_pend | output | 1 | Refresh pending |
| cmd_valid | output | 1 | Command issued this cycle |
| cmd_op | output | 3 | 0 none, 1 ACTIVATE, 2 READ, 3 WRITE, 4 PRECHARGE, 5 REFRESH |
| cmd_row | output | ROW_W | Row for ACTIVATE |
| cmd_col | output | COL_W | Column for READ/WRITE |

## Verification
The assertions take for granted that the request fields stay stable during the cycle in which valid is raised. They also assume the configuration inputs do not change while busy is high, because the classification-to-command checks rely on the policy and counts being fixed for the length of a sequence. The bench changes the page policy, the delay counts and the refresh interval only while the block is idle. It drives requests on the falling edge and holds them until they are accepted. It turns the interval counter off again right after the refresh it was meant to cause.

// File: rtl/bank_seq.sv
module bank_seq #(
  parameter int ROW_W  = 14,
  parameter int COL_W  = 10,
  parameter int DLY_W  = 4,
  parameter int RINT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_closed,
  input  logic [DLY_W-1:0]  cfg_trcd,
  input  logic [DLY_W-1:0]  cfg_trp,
  input  logic [DLY_W-1:0]  cfg_tcl,
  input  logic [DLY_W-1:0]  cfg_trfc,
  input  logic [RINT_W-1:0] cfg_ref_int,
  input  logic              ref_req,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ROW_W-1:0]  req_row,
  input  logic [COL_W-1:0]  req_col,
  input  logic              req_we,
  output logic              busy,
  output logic              cls_valid,
  output logic [1:0]        cls,
  output logic              ref_pend,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ROW_W-1:0]  cmd_row,
  output logic [COL_W-1:0]  cmd_col
);
  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ACT, S_CAS, S_REF, S_WAIT} st_t;

  st_t              state, pre_next, wnext, tgt;
  logic [DLY_W-1:0] cnt, dly;
  logic             open_q, we_q;
  logic [ROW_W-1:0] open_row, row_q;
  logic [COL_W-1:0] col_q;
  logic [RINT_W-1:0] ref_cnt;
  logic             ref_tick, hit;

  assign busy      = state != S_IDLE;
  assign req_ready = !busy && !ref_pend;
  assign hit       = open_q && open_row == req_row;
  assign cls_valid = req_valid && req_ready;
  assign cls       = hit ? 2'd1 : (open_q ? 2'd3 : 2'd2);
  assign cmd_valid = state inside {S_PRE, S_ACT, S_CAS, S_REF};
  assign cmd_row   = row_q;
  assign cmd_col   = col_q;
  assign ref_tick  = cfg_ref_int != '0 && ref_cnt == cfg_ref_int - RINT_W'(1);

  always_comb begin
    case (state)
      S_PRE:   cmd_op = 3'd4;
      S_ACT:   cmd_op = 3'd1;
      S_CAS:   cmd_op = we_q ? 3'd3 : 3'd2;
      S_REF:   cmd_op = 3'd5;
      default: cmd_op = 3'd0;
    endcase
  end

  always_comb begin
    dly = '0;
    tgt = S_IDLE;
    case (state)
      S_PRE: begin dly = cfg_trp;  tgt = pre_next; end
      S_ACT: begin dly = cfg_trcd; tgt = S_CAS; end
      S_CAS: begin dly = cfg_tcl;  tgt = cfg_closed ? S_PRE : S_IDLE; end
      S_REF: begin dly = cfg_trfc; tgt = S_IDLE; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      ref_cnt  <= (cfg_ref_int == '0 || ref_tick) ? '0 : ref_cnt + RINT_W'(1);
      ref_pend <= ref_req || ref_tick || (ref_pend && state != S_REF);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      pre_next <= S_IDLE;
      wnext    <= S_IDLE;
      cnt      <= '0;
      open_q   <= 1'b0;
      open_row <= '0;
      row_q    <= '0;
      col_q    <= '0;
      we_q     <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ref_pend) begin
            state    <= open_q ? S_PRE : S_REF;
            pre_next <= S_REF;
          end else if (req_valid) begin
            row_q    <= req_row;
            col_q    <= req_col;
            we_q     <= req_we;
            pre_next <= S_ACT;
            state    <= hit ? S_CAS : (open_q ? S_PRE : S_ACT);
          end
        end
        S_WAIT: begin
          cnt <= cnt - DLY_W'(1);
          if (cnt == DLY_W'(1)) state <= wnext;
        end
        default: begin
          if (state == S_PRE) open_q <= 1'b0;
          if (state == S_ACT) begin
            open_q   <= 1'b1;
            open_row <= row_q;
          end
          if (state == S_CAS) pre_next <= S_IDLE;
          if (dly == '0) state <= tgt;
          else begin
            state <= S_WAIT;
            cnt   <= dly;
            wnext <= tgt;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/bank_seq_chk.sv
module bank_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       busy,
  input logic       cls_valid,
  input logic [1:0] cls,
  input logic       ref_pend,
  input logic       cmd_valid,
  input logic [2:0] cmd_op
);
  p_ready_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  p_hit_cas_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls == 2'd1) |=> (cmd_valid && (cmd_op == 3'd2 || cmd_op == 3'd3)));
  p_miss_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls == 2'd2) |=> (cmd_valid && cmd_op == 3'd1));
  p_conf_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_valid && cls == 2'd3) |=> (cmd_valid && cmd_op == 3'd4));
  p_ref_pend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd5) |-> ref_pend);
  p_pend_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pend |-> !req_ready);
endmodule

bind bank_seq bank_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .busy(busy),
  .cls_valid(cls_valid), .cls(cls), .ref_pend(ref_pend),
  .cmd_valid(cmd_valid), .cmd_op(cmd_op)
);

// File: tb/bank_seq_tb_top.sv
module bank_seq_tb_top;
  localparam int ROW_W = 14, COL_W = 10, DLY_W = 4, RINT_W = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_closed = 0;
  logic [DLY_W-1:0] cfg_trcd = 2, cfg_trp = 3, cfg_tcl = 1, cfg_trfc = 4;
  logic [RINT_W-1:0] cfg_ref_int = 0;
  logic ref_req = 0, req_valid = 0, req_we = 0;
  logic [ROW_W-1:0] req_row = 0;
  logic [COL_W-1:0] req_col = 0;
  logic req_ready, busy, cls_valid, ref_pend, cmd_valid;
  logic [1:0] cls;
  logic [2:0] cmd_op;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;

  always #5 clk = ~clk;

  bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DLY_W(DLY_W), .RINT_W(RINT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_closed(cfg_closed), .cfg_trcd(cfg_trcd),
    .cfg_trp(cfg_trp), .cfg_tcl(cfg_tcl), .cfg_trfc(cfg_trfc),
    .cfg_ref_int(cfg_ref_int), .ref_req(ref_req), .req_valid(req_valid),
    .req_ready(req_ready), .req_row(req_row), .req_col(req_col), .req_we(req_we),
    .busy(busy), .cls_valid(cls_valid), .cls(cls), .ref_pend(ref_pend),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_row(cmd_row), .cmd_col(cmd_col));

  typedef struct { int op; int row; int col; int gap; string tag; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0, cyc = 0, last_cyc = 0;
  bit m_open = 0;
  int m_row = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic push(input int op, input int row, input int col, input int gap, input string tag);
    exp_t e;
    e.op = op; e.row = row; e.col = col; e.gap = gap; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && cmd_valid) begin
      if (q.size() == 0) chk(0, "unexpected command", int'(cmd_op), 0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(int'(cmd_op) == e.op, {e.tag, " op"}, int'(cmd_op), e.op);
        if (e.op == 1) chk(int'(cmd_row) == e.row, {e.tag, " row"}, int'(cmd_row), e.row);
        if (e.op == 2 || e.op == 3) chk(int'(cmd_col) == e.col, {e.tag, " col"}, int'(cmd_col), e.col);
        if (e.gap >= 0) chk(cyc - last_cyc == e.gap, {e.tag, " gap R6"}, cyc - last_cyc, e.gap);
      end
      last_cyc = cyc;
    end
  end

  task automatic send(input int row, input int col, input bit we, input int first_gap);
    int ec, op;
    op = we ? 3 : 2;
    @(negedge clk);
    req_valid = 1; req_row = ROW_W'(row); req_col = COL_W'(col); req_we = we;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    ec = !m_open ? 2 : (m_row == row ? 1 : 3);
    chk(cls_valid && int'(cls) == ec, ec == 1 ? "R2 cls hit" : (ec == 2 ? "R3 cls miss" : "R4 cls conflict"), int'(cls), ec);
    if (ec == 1) push(op, row, col, first_gap, "R2 hit cas");
    else if (ec == 2) begin
      push(1, row, col, first_gap, "R3 act");
      push(op, row, col, int'(cfg_trcd) + 1, "R3 cas");
    end else begin
      push(4, row, col, first_gap, "R4 pre");
      push(1, row, col, int'(cfg_trp) + 1, "R4 act");
      push(op, row, col, int'(cfg_trcd) + 1, "R4 cas");
    end
    if (cfg_closed) begin
      push(4, row, col, int'(cfg_tcl) + 1, "R9 closing pre");
      m_open = 0;
    end else begin
      m_open = 1; m_row = row;
    end
    @(negedge clk);
    req_valid = 0;
    chk(busy && !req_ready, "R5 ready low while busy", int'(req_ready), 0);
    while (busy) @(negedge clk);
    chk(q.size() == 0, "sequence complete", q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !busy && !cmd_valid && !ref_pend, "R1 reset state", {req_ready, busy, cmd_valid, ref_pend}, 8);

    send(5, 3, 0, -1);
    send(5, 7, 1, -1);
    send(9, 1, 0, -1);
    send(9, 2, 0, -1);

    // R10: open row held through idle cycles
    repeat (5) @(negedge clk);
    send(9, 8, 1, -1);

    // R7/R8: refresh request with row 9 open
    ref_req = 1;
    @(negedge clk);
    ref_req = 0;
    #1;
    chk(ref_pend && !req_ready, "R8 pending refresh blocks requests", int'(req_ready), 0);
    push(4, 0, 0, -1, "R7 pre before refresh");
    push(5, 0, 0, int'(cfg_trp) + 1, "R7 refresh");
    m_open = 0;
    send(9, 4, 0, int'(cfg_trfc) + 2);
    chk(!ref_pend, "R8 pend cleared", int'(ref_pend), 0);

    // R9: closed-page policy
    cfg_closed = 1;
    send(9, 5, 1, -1);
    send(9, 6, 0, -1);
    send(2, 1, 0, -1);
    cfg_closed = 0;

    // R8: interval counter with a row open
    send(3, 3, 0, -1);
    cfg_ref_int = 40;
    push(4, 0, 0, -1, "R8 interval pre");
    push(5, 0, 0, int'(cfg_trp) + 1, "R8 interval refresh");
    m_open = 0;
    begin
      int guard = 0;
      while (q.size() != 0 && guard < 500) begin @(negedge clk); guard++; end
    end
    cfg_ref_int = 0;
    while (busy) @(negedge clk);
    chk(q.size() == 0 && !ref_pend, "R8 interval refresh done", q.size(), 0);

    // R6: zero activate-to-column delay
    cfg_trcd = 0;
    send(7, 7, 1, -1);
    cfg_trcd = 2;
    send(7, 9, 0, -1);

    repeat (5) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule